// File: doc/BRIEF.md
# Stator Flux and Torque Estimator

This block turns one set of motor samples into the four quantities a hysteresis torque controller needs: the stationary-frame stator flux components, the flux magnitude, and the electromagnetic torque. On a start strobe it captures two phase currents, the DC link voltage, the three present gate states and the constants it needs. These constants are the stator resistance, the integration step and the pole-pair count. It then works through the estimate on one shared multiplier. The phase voltages are not measured. They are rebuilt from the gate states and the DC link voltage.

The two flux components are the block's only memory between loops. Each is advanced by one forward-Euler step per loop through the same multiply path, and starts from zero after reset. The magnitude comes from an iterative bit-by-bit square root. All four results are loaded together at the end of the loop and marked by a one-cycle valid pulse. They then hold until the next loop ends.

All values are signed fixed point with `W` = 16 bits and `F` = 12 fraction bits, so 4096 stands for 1.0. A rounded product means `(a*b + 2^(F-1)) >>> F`, which rounds to nearest with ties toward plus infinity. The result is then clamped to [-32768, 32767]. A saturated sum is clamped to the same range.

Top module: `est_top`

The controller visits its states in this order:
- `ST_IDLE` goes to `ST_ISQ` on start.
- It then steps through `ST_VSD`, `ST_VSQ`, `ST_DROPD`, `ST_INTD`, `ST_DROPQ`, `ST_INTQ`, `ST_CROSS1`, `ST_CROSS2`, `ST_SCALE`, `ST_SQD` and `ST_SQQ`, one cycle each.
- `ST_ROOT` waits for the square root to finish, then moves to `ST_DONE`.
- `ST_DONE` returns to `ST_IDLE`.

## Requirements
- R1: After reset, `busy` and `out_valid` are low and all four outputs read 0; the flux state starts from 0.
- R2: A start seen while idle raises `busy` on the next cycle and captures all inputs. A start while busy is ignored: the loop is not restarted, the inputs are not re-sampled, and no extra valid pulse follows.
- R3: The d current is `ia` and the q current is the rounded product of (`ia` + 2·`ib`) and round(2^F/√3).
- R4: `gates[0]`, `gates[1]` and `gates[2]` are the phase a, b and c upper switch states. The d voltage is the rounded product of `vdc`·(2Sa−Sb−Sc) and round(2^F/3). The q voltage is the rounded product of `vdc`·(Sb−Sc) and round(2^F/√3).
- R5: Each loop first advances d and then q by adding the rounded product of `ts` and the saturated difference (v − rounded `rs`·i) to the old flux, with saturation.
- R6: Torque is the rounded product of the saturated difference (rounded φd·iq − rounded φq·id) and 1.5·`pole_pairs`, using the newly updated flux.
- R7: `flux_mag` is floor(sqrt(φd² + φq²)) from the exact squares, clamped to 32767, and never negative.
- R8: `out_valid` is a single-cycle pulse in the last busy cycle. All four outputs change only in that cycle.
- R9: Every loop takes the same number of cycles from start to `out_valid`, at most 40.
- R10: Every product rounds to nearest (ties upward) and every result saturates to the 16-bit range instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches one estimation loop when idle |
| ia | input | 16 | Phase a current, signed Q3.12 |
| ib | input | 16 | Phase b current, signed Q3.12 |
| vdc | input | 16 | DC link voltage, signed Q3.12 |
| gates | input | 3 | Upper switch states: bit 0 = a, bit 1 = b, bit 2 = c |
| rs | input | 16 | Stator resistance, signed Q3.12 |
| ts | input | 16 | Integration step, signed Q3.12 |
| pole_pairs | input | 3 | Pole-pair count |
| busy | output | 1 | High from the cycle after start through the valid cycle |
| out_valid | output | 1 | One-cycle pulse: all four results updated |
| flux_d | output | 16 | d-axis stator flux |
| flux_q | output | 16 | q-axis stator flux |
| flux_mag | output | 16 | Stator flux magnitude |
| torque | output | 16 | Electromagnetic torque |

## Verification
The assertions assume that `rst_n` is held low for at least one edge before the first start, and that `start` and all data inputs change only away from the rising edge. The bench keeps to this by driving on the falling edge. It also relies on the captured inputs, so it deliberately changes the data pins and pulses `start` in the middle of a loop, to show that a running loop never re-samples them. The latency bound assumes the square root always runs its full fixed iteration count, whatever the radicand. The bench therefore uses zero, small and saturated flux values and expects the same latency for all of them.

// File: rtl/est_pkg.sv
package est_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ISQ, ST_VSD, ST_VSQ, ST_DROPD, ST_INTD, ST_DROPQ, ST_INTQ,
        ST_CROSS1, ST_CROSS2, ST_SCALE, ST_SQD, ST_SQQ, ST_ROOT, ST_DONE
    } est_state_e;

    // floor square root for elaboration-time constants, one bit per step
    function automatic longint const_isqrt(input longint v);
        longint r;
        r = 0;
        for (int i = 31; i >= 0; i--) begin
            if ((r + (longint'(1) << i)) * (r + (longint'(1) << i)) <= v)
                r = r + (longint'(1) << i);
        end
        return r;
    endfunction

endpackage

// File: rtl/est_mul.sv
module est_mul #(
    parameter int W  = 16,
    parameter int F  = 12,
    parameter int WM = W + 2
) (
    input  logic signed [WM-1:0]   a,
    input  logic signed [WM-1:0]   b,
    output logic signed [2*WM-1:0] raw,
    output logic signed [W-1:0]    rnd
);
    localparam int PW = 2 * WM;
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (F - 1);
    localparam logic signed [PW-1:0] MAXP = (PW'(1) <<< (W - 1)) - PW'(1);
    localparam logic signed [PW-1:0] MINP = -MAXP - PW'(1);

    logic signed [PW-1:0] shifted;

    always_comb begin
        raw     = PW'(a) * PW'(b);
        shifted = (raw + HALF) >>> F;
        if (shifted > MAXP)      rnd = MAXP[W-1:0];
        else if (shifted < MINP) rnd = MINP[W-1:0];
        else                     rnd = shifted[W-1:0];
    end
endmodule

// File: rtl/est_isqrt.sv
module est_isqrt #(
    parameter int RW = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [2*RW-1:0] rad,
    output logic [RW-1:0]   root,
    output logic            fin
);
    localparam int CW = $clog2(RW);

    logic [2*RW-1:0] rad_r;
    logic [RW:0]     rem;
    logic [RW+2:0]   rem_n, trial;
    logic [CW-1:0]   cnt;
    logic            run;

    always_comb begin
        rem_n = {rem, rad_r[2*RW-1 -: 2]};
        trial = {1'b0, root, 2'b01};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rad_r <= '0;
            rem   <= '0;
            root  <= '0;
            cnt   <= '0;
            run   <= 1'b0;
            fin   <= 1'b0;
        end else if (go) begin
            rad_r <= rad;
            rem   <= '0;
            root  <= '0;
            cnt   <= CW'(RW - 1);
            run   <= 1'b1;
            fin   <= 1'b0;
        end else if (run) begin
            rad_r <= rad_r << 2;
            if (rem_n >= trial) begin
                rem  <= (RW+1)'(rem_n - trial);
                root <= {root[RW-2:0], 1'b1};
            end else begin
                rem  <= rem_n[RW:0];
                root <= {root[RW-2:0], 1'b0};
            end
            cnt <= cnt - CW'(1);
            if (cnt == '0) begin
                run <= 1'b0;
                fin <= 1'b1;
            end
        end else begin
            fin <= 1'b0;
        end
    end
endmodule

// File: rtl/est_top.sv
module est_top
    import est_pkg::*;
#(
    parameter int W   = 16,
    parameter int F   = 12,
    parameter int PPW = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic signed [W-1:0] ia,
    input  logic signed [W-1:0] ib,
    input  logic signed [W-1:0] vdc,
    input  logic [2:0]          gates,
    input  logic signed [W-1:0] rs,
    input  logic signed [W-1:0] ts,
    input  logic [PPW-1:0]      pole_pairs,
    output logic                busy,
    output logic                out_valid,
    output logic signed [W-1:0] flux_d,
    output logic signed [W-1:0] flux_q,
    output logic signed [W-1:0] flux_mag,
    output logic signed [W-1:0] torque
);
    localparam int WM        = W + 2;
    localparam int PW        = 2 * WM;
    localparam int RW        = WM;
    localparam int THIRD     = ((1 << F) + 1) / 3;
    localparam int INV_SQRT3 = int'((const_isqrt((longint'(1) << (2 * F + 2)) / 3) + 1) / 2);
    localparam logic [RW-1:0] MAG_MAX = RW'((1 << (W - 1)) - 1);

    function automatic logic signed [W-1:0] sat1(input logic signed [W:0] x);
        if (x[W] != x[W-1]) return x[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        return x[W-1:0];
    endfunction

    est_state_e state, state_n;

    logic signed [W-1:0]  ia_r, ib_r, vdc_r, rs_r, ts_r;
    logic [2:0]           g_r;
    logic [PPW-1:0]       pp_r;
    logic signed [W-1:0]  isq, vsd, vsq, drop, phid, phiq, p1, diff, te_w;
    logic [PW-1:0]        acc;
    logic signed [WM-1:0] mul_a, mul_b;
    logic signed [PW-1:0] raw;
    logic signed [W-1:0]  rnd, err;
    logic signed [3:0]    kd, kq;
    logic [RW-1:0]        root;
    logic                 sq_go, sq_fin;

    est_mul #(.W(W), .F(F), .WM(WM)) u_mul (
        .a(mul_a), .b(mul_b), .raw(raw), .rnd(rnd)
    );

    assign sq_go = (state == ST_SQQ);

    est_isqrt #(.RW(RW)) u_sqrt (
        .clk(clk), .rst_n(rst_n), .go(sq_go),
        .rad(acc + PW'(raw)), .root(root), .fin(sq_fin)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (start) state_n = ST_ISQ;
            ST_ISQ:    state_n = ST_VSD;
            ST_VSD:    state_n = ST_VSQ;
            ST_VSQ:    state_n = ST_DROPD;
            ST_DROPD:  state_n = ST_INTD;
            ST_INTD:   state_n = ST_DROPQ;
            ST_DROPQ:  state_n = ST_INTQ;
            ST_INTQ:   state_n = ST_CROSS1;
            ST_CROSS1: state_n = ST_CROSS2;
            ST_CROSS2: state_n = ST_SCALE;
            ST_SCALE:  state_n = ST_SQD;
            ST_SQD:    state_n = ST_SQQ;
            ST_SQQ:    state_n = ST_ROOT;
            ST_ROOT:   if (sq_fin) state_n = ST_DONE;
            ST_DONE:   state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // shared multiplier operand selection
    always_comb begin
        kd    = $signed({2'b00, g_r[0], 1'b0}) - $signed({3'b000, g_r[1]}) - $signed({3'b000, g_r[2]});
        kq    = $signed({3'b000, g_r[1]}) - $signed({3'b000, g_r[2]});
        err   = sat1((W+1)'((state == ST_INTD) ? vsd : vsq) - (W+1)'(drop));
        mul_a = '0;
        mul_b = '0;
        unique case (state)
            ST_ISQ:    begin mul_a = WM'(ia_r) + (WM'(ib_r) <<< 1); mul_b = WM'(INV_SQRT3); end
            ST_VSD:    begin mul_a = WM'(vdc_r) * WM'(kd);        mul_b = WM'(THIRD);     end
            ST_VSQ:    begin mul_a = WM'(vdc_r) * WM'(kq);        mul_b = WM'(INV_SQRT3); end
            ST_DROPD:  begin mul_a = WM'(rs_r);  mul_b = WM'(ia_r); end
            ST_INTD:   begin mul_a = WM'(ts_r);  mul_b = WM'(err);  end
            ST_DROPQ:  begin mul_a = WM'(rs_r);  mul_b = WM'(isq);  end
            ST_INTQ:   begin mul_a = WM'(ts_r);  mul_b = WM'(err);  end
            ST_CROSS1: begin mul_a = WM'(phid);  mul_b = WM'(isq);  end
            ST_CROSS2: begin mul_a = WM'(phiq);  mul_b = WM'(ia_r); end
            ST_SCALE:  begin mul_a = WM'(diff);  mul_b = WM'((3 * int'(pp_r)) << (F - 1)); end
            ST_SQD:    begin mul_a = WM'(phid);  mul_b = WM'(phid); end
            ST_SQQ:    begin mul_a = WM'(phiq);  mul_b = WM'(phiq); end
            default:   begin mul_a = '0; mul_b = '0; end
        endcase
    end

    // datapath and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {ia_r, ib_r, vdc_r, rs_r, ts_r} <= '0;
            g_r  <= '0;
            pp_r <= '0;
            {isq, vsd, vsq, drop, phid, phiq, p1, diff, te_w} <= '0;
            acc  <= '0;
            {flux_d, flux_q, flux_mag, torque} <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    ia_r <= ia;  ib_r <= ib;  vdc_r <= vdc;
                    rs_r <= rs;  ts_r <= ts;  g_r <= gates;
                    pp_r <= pole_pairs;
                end
                ST_ISQ:    isq  <= rnd;
                ST_VSD:    vsd  <= rnd;
                ST_VSQ:    vsq  <= rnd;
                ST_DROPD:  drop <= rnd;
                ST_INTD:   phid <= sat1((W+1)'(phid) + (W+1)'(rnd));
                ST_DROPQ:  drop <= rnd;
                ST_INTQ:   phiq <= sat1((W+1)'(phiq) + (W+1)'(rnd));
                ST_CROSS1: p1   <= rnd;
                ST_CROSS2: diff <= sat1((W+1)'(p1) - (W+1)'(rnd));
                ST_SCALE:  te_w <= rnd;
                ST_SQD:    acc  <= PW'(raw);
                ST_ROOT: if (sq_fin) begin
                    flux_d   <= phid;
                    flux_q   <= phiq;
                    flux_mag <= (root > MAG_MAX) ? MAG_MAX[W-1:0] : root[W-1:0];
                    torque   <= te_w;
                end
                default: ;
            endcase
        end
    end

    // status outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        out_valid = (state == ST_DONE);
    end
endmodule

// File: rtl/est_chk.sv
module est_chk #(
    parameter int W       = 16,
    parameter int LAT_MAX = 40
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                busy,
    input logic                out_valid,
    input logic signed [W-1:0] flux_d,
    input logic signed [W-1:0] flux_q,
    input logic signed [W-1:0] flux_mag,
    input logic signed [W-1:0] torque
);
    logic [7:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= (busy_cnt == 8'hff) ? busy_cnt : busy_cnt + 8'd1;
        else           busy_cnt <= '0;
    end

    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r2_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !out_valid) |=> busy);

    a_r8_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> (!out_valid && !busy));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(flux_d) && $stable(flux_q) && $stable(flux_mag) && $stable(torque)));

    a_r7_mag_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        !flux_mag[W-1]);

    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < 8'(LAT_MAX)));
endmodule

bind est_top est_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .out_valid(out_valid),
    .flux_d(flux_d), .flux_q(flux_q), .flux_mag(flux_mag), .torque(torque)
);

// File: tb/sim_est_top.sv
module sim_est_top;
    localparam int F = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic signed [15:0] ia = '0, ib = '0, vdc = '0, rs = '0, ts = '0;
    logic [2:0]        gates = '0;
    logic [2:0]        pole_pairs = 3'd1;
    logic              busy, out_valid;
    logic signed [15:0] flux_d, flux_q, flux_mag, torque;

    int checks = 0;
    int errors = 0;
    int lat_ref = -1;
    longint m_phid = 0, m_phiq = 0;
    longint c_third, c_isq3;

    always #2 clk = ~clk;

    est_top u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ia(ia), .ib(ib), .vdc(vdc),
        .gates(gates), .rs(rs), .ts(ts), .pole_pairs(pole_pairs),
        .busy(busy), .out_valid(out_valid), .flux_d(flux_d), .flux_q(flux_q),
        .flux_mag(flux_mag), .torque(torque)
    );

    function automatic longint sat(input longint x);
        if (x > 32767)  return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    function automatic longint mulr(input longint a, input longint b);
        return sat((a * b + (longint'(1) << (F - 1))) >>> F);
    endfunction

    function automatic longint fsqrt(input longint v);
        longint r;
        r = longint'($sqrt(real'(v)));
        while (r * r > v) r--;
        while ((r + 1) * (r + 1) <= v) r++;
        return r;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one loop of the estimator; computes the expected results from the requirements
    task automatic model(input longint a, input longint b, input longint e, input logic [2:0] g,
                         input longint r, input longint t, input longint pp,
                         output longint efd, output longint efq, output longint emag, output longint ete);
        longint sa, sb, sc, iq, vd, vq, p1, p2;
        sa = g[0]; sb = g[1]; sc = g[2];
        iq = mulr(a + 2 * b, c_isq3);                               // R3
        vd = mulr(e * (2 * sa - sb - sc), c_third);                 // R4
        vq = mulr(e * (sb - sc), c_isq3);
        m_phid = sat(m_phid + mulr(t, sat(vd - mulr(r, a))));       // R5
        m_phiq = sat(m_phiq + mulr(t, sat(vq - mulr(r, iq))));
        p1 = mulr(m_phid, iq);
        p2 = mulr(m_phiq, a);
        ete  = mulr(sat(p1 - p2), 3 * pp * (longint'(1) << (F - 1))); // R6
        emag = fsqrt(m_phid * m_phid + m_phiq * m_phiq);              // R7
        if (emag > 32767) emag = 32767;
        efd = m_phid;
        efq = m_phiq;
    endtask

    task automatic run_loop(input string tag, input longint a, input longint b, input longint e,
                            input logic [2:0] g, input longint r, input longint t, input longint pp);
        longint efd, efq, emag, ete;
        int lat;
        @(negedge clk);
        ia = 16'(a); ib = 16'(b); vdc = 16'(e); gates = g;
        rs = 16'(r); ts = 16'(t); pole_pairs = 3'(pp);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R2 busy after start"}, busy, 1);
        lat = 1;
        while (!out_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        model(a, b, e, g, r, t, pp, efd, efq, emag, ete);
        chk({tag, " R8 valid seen"}, out_valid, 1);
        chk({tag, " R5 flux_d"}, flux_d, efd);
        chk({tag, " R5 flux_q"}, flux_q, efq);
        chk({tag, " R7 flux_mag"}, flux_mag, emag);
        chk({tag, " R6 torque"}, torque, ete);
        if (lat_ref < 0) lat_ref = lat;
        chk({tag, " R9 fixed latency"}, lat, lat_ref);
        chk({tag, " R9 latency bound"}, (lat <= 40) ? 1 : 0, 1);
        @(negedge clk);
        chk({tag, " R8 single pulse"}, out_valid, 0);
        chk({tag, " R8 hold flux_d"}, flux_d, efd);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 flux_d", flux_d, 0);
        chk("R1 flux_q", flux_q, 0);
        chk("R1 flux_mag", flux_mag, 0);
        chk("R1 torque", torque, 0);
    endtask

    task automatic t_active();
        run_loop("active R3 R4", 1000, -500, 8192, 3'b001, 700, 400, 2);
        run_loop("active2 R3 R4", -1500, 2200, 12000, 3'b011, 300, 900, 2);
    endtask

    task automatic t_sweep();
        for (int k = 0; k < 8; k++)
            run_loop("sweep R4", 600 - 150 * k, 250 * k - 900, 6000 + 500 * k, 3'(k), 500, 700, 3);
    endtask

    task automatic t_zero_vec();
        run_loop("zero000 R4 R5", 2000, 1000, 20000, 3'b000, 4096, 2000, 2);
        run_loop("zero111 R4 R5", -2000, 500, 20000, 3'b111, 4096, 2000, 2);
    endtask

    task automatic t_poles();
        run_loop("pp1 R6", 3000, -1200, 9000, 3'b100, 200, 1500, 1);
        run_loop("pp7 R6", 3000, -1200, 9000, 3'b010, 200, 1500, 7);
    endtask

    task automatic t_ignore_start();
        longint efd, efq, emag, ete;
        int lat, pulses;
        @(negedge clk);
        ia = 16'(1234); ib = 16'(-321); vdc = 16'(10000); gates = 3'b101;
        rs = 16'(600); ts = 16'(800); pole_pairs = 3'd2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        ia = 16'(-30000); ib = 16'(30000); vdc = 16'(32000); gates = 3'b010;
        rs = 16'(9000); ts = 16'(9000); pole_pairs = 3'd7;
        start = 1'b1;
        @(negedge clk);
        chk("R2 busy held through ignored start", busy, 1);
        lat = 6;
        while (!out_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        model(1234, -321, 10000, 3'b101, 600, 800, 2, efd, efq, emag, ete);
        chk("R2 ignored start latency", lat, lat_ref);
        chk("R2 flux_d uses first inputs", flux_d, efd);
        chk("R2 flux_q uses first inputs", flux_q, efq);
        chk("R2 torque uses first inputs", torque, ete);
        pulses = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (out_valid) pulses++;
        end
        chk("R2 no restart after ignored start", pulses, 0);
        chk("R2 idle after loop", busy, 0);
    endtask

    task automatic t_saturate();
        for (int k = 0; k < 3; k++)
            run_loop("sat+ R10 R7", 0, 0, 32767, 3'b001, 0, 32767, 1);
        chk("R10 flux_d clamps high", flux_d, 32767);
        chk("R7 magnitude clamps", flux_mag, 32767);
        for (int k = 0; k < 5; k++)
            run_loop("sat- R10", 0, 0, 32767, 3'b110, 0, 32767, 7);
        chk("R10 flux_d clamps low", flux_d, -32768);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        c_third = longint'($rtoi((2.0 ** F) / 3.0 + 0.5));
        c_isq3  = longint'($rtoi((2.0 ** F) / $sqrt(3.0) + 0.5));
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_active();
        t_sweep();
        t_zero_vec();
        t_poles();
        t_ignore_start();
        t_saturate();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule